// File: doc/BRIEF.md
# Delayed-Branch Program Counter Sequencer

This block holds the fetch address state of a 32-bit RISC front end that has one architectural delay slot. The state is a pair of registers: the address of the instruction now retiring (`fetchPc`) and the address that follows it (`nextPc`). Each time an instruction retires, the pair moves forward by one. A taken control transfer is written into the second register of the pair, not the first. The instruction after a branch, in its delay slot, therefore always gets fetched, and the redirect takes effect one instruction later.

The block also decides whether the delay-slot instruction is discarded. A conditional branch with its annul bit set discards the slot only when it falls through. A branch of the unconditional kind ("always" or "never") with annul set discards the slot in both cases. A discarded instruction still moves the address pair forward, but its write-back enable stays low and its own branch fields have no effect. The branch condition is evaluated elsewhere and arrives as the `brTaken` input. The block forms the PC-relative target itself, from a 22-bit word displacement for branches or a 30-bit word displacement for calls.

Top module: `delay_slot_pc_seq`

## Requirements
- R1: While `rstN` is low and after it is released, `fetchPc` is 0x00000000, `nextPc` is 0x00000004 and `squash` is 0.
- R2: When `retire` is 0, `fetchPc`, `nextPc` and `squash` keep their values at the next clock edge, whatever the other inputs are.
- R3: On a retire with no control transfer, `fetchPc` takes the old `nextPc` and `nextPc` becomes the old `nextPc` plus 4.
- R4: `target` equals `fetchPc` plus four times the sign-extended `dispIn[21:0]` when `isCall` is 0. On a retiring, non-squashed instruction with `isBranch`=1, `isCall`=0 and `brTaken`=1, `fetchPc` takes the old `nextPc` and `nextPc` takes `target`.
- R5: When `isCall` is 1, `target` equals `fetchPc` plus four times the sign-extended `dispIn[29:0]`. A retiring, non-squashed call always loads `target` into `nextPc` and never sets `squash`. A call takes priority over `isBranch`, `isUncond`, `brTaken` and `annul`.
- R6: A retiring, non-squashed conditional branch (`isUncond`=0) with `annul`=1 sets `squash` only when `brTaken` is 0. With `annul`=0 it never sets `squash`.
- R7: A retiring, non-squashed branch with `isUncond`=1 and `annul`=1 sets `squash` whether `brTaken` is 1 or 0.
- R8: While `squash` is 1, a retiring instruction drives `wbEn` low, advances the pair sequentially as in R3 even if its branch inputs request a transfer, and clears `squash`.
- R9: All address arithmetic wraps modulo 2^32, and bits [1:0] of `fetchPc`, `nextPc` and `target` are always 0.
- R10: A taken branch placed in the delay slot of another taken branch is handled as an ordinary branch. The first target is fetched once, and then fetching continues at the second target.
- R11: `wbEn` is 1 exactly when `retire` is 1 and `squash` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| retire | input | 1 | The instruction at `fetchPc` retires this cycle |
| isBranch | input | 1 | The retiring instruction is a PC-relative branch |
| isUncond | input | 1 | The branch condition is of the always/never kind |
| isCall | input | 1 | The retiring instruction is a call (30-bit displacement) |
| brTaken | input | 1 | Branch condition result from the condition unit |
| annul | input | 1 | Annul bit of the branch |
| dispIn | input | 30 | Word displacement; bits [21:0] are used for branches |
| fetchPc | output | 32 | Address of the current instruction |
| nextPc | output | 32 | Address of the instruction after it |
| target | output | 32 | PC-relative target for the current inputs |
| squash | output | 1 | The current instruction is an annulled delay slot |
| wbEn | output | 1 | Write-back enable of the retiring instruction |

## Verification
Straight-line retires separate the sequential step from holding the state and from an early redirect. Taken and untaken conditional branches, each with annul set and clear, are set against unconditional branches with annul, and this pairing shows whether the annul rule depends on the branch kind. A squashed slot that carries a taken branch of its own shows whether discarded instructions are kept from redirecting. Back-to-back taken branches, a negative displacement and a call that wraps below address zero test the delay-slot ordering, sign extension and modulo arithmetic.

// File: rtl/dsseq_pkg.sv
package dsseq_pkg;

  // Strobes from the control unit to the address datapath.
  typedef struct packed {
    logic advance;     // shift the address pair by one instruction
    logic loadTarget;  // next address takes the PC-relative target
    logic callDisp;    // target uses the long (call) displacement
  } seqStrobe_t;

endpackage

// File: rtl/dsseq_ctrl.sv
module dsseq_ctrl
  import dsseq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       retire,
  input  logic       isBranch,
  input  logic       isUncond,
  input  logic       isCall,
  input  logic       brTaken,
  input  logic       annul,
  output seqStrobe_t strobe,
  output logic       squash,
  output logic       wbEn
);

  logic annulPend;
  logic live;
  logic branchOnly;
  logic doTransfer;
  logic setAnnul;

  // An annulled slot retires but is otherwise inert.
  assign live       = retire & ~annulPend;
  assign branchOnly = isBranch & ~isCall;
  assign doTransfer = live & (isCall | (branchOnly & brTaken));
  // Conditional kind annuls on fall-through only; unconditional kind always.
  assign setAnnul   = live & branchOnly & annul & (isUncond | ~brTaken);

  always_comb begin
    strobe            = '0;
    strobe.advance    = retire;
    strobe.loadTarget = doTransfer;
    strobe.callDisp   = isCall;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      annulPend <= 1'b0;
    end else if (retire) begin
      annulPend <= setAnnul;
    end
  end

  assign squash = annulPend;
  assign wbEn   = live;

endmodule

// File: rtl/dsseq_datapath.sv
module dsseq_datapath
  import dsseq_pkg::*;
#(
  parameter int unsigned ADDR_W      = 32,
  parameter int unsigned BR_DISP_W   = 22,
  parameter int unsigned CALL_DISP_W = 30,
  parameter logic [ADDR_W-1:0] RESET_PC = '0
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  seqStrobe_t             strobe,
  input  logic [CALL_DISP_W-1:0] dispIn,
  output logic [ADDR_W-1:0]      pcQ,
  output logic [ADDR_W-1:0]      npcQ,
  output logic [ADDR_W-1:0]      targetAddr
);

  localparam int unsigned INSN_BYTES = 4;
  localparam int unsigned WORD_SHIFT = $clog2(INSN_BYTES);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(INSN_BYTES);

  logic signed [BR_DISP_W-1:0]   brDisp;
  logic signed [CALL_DISP_W-1:0] callDisp;
  logic signed [ADDR_W-1:0]      brExt;
  logic signed [ADDR_W-1:0]      callExt;
  logic [ADDR_W-1:0]             wordOff;
  logic [ADDR_W-1:0]             byteOff;
  logic [ADDR_W-1:0]             seqAddr;

  assign brDisp   = dispIn[BR_DISP_W-1:0];
  assign callDisp = dispIn;
  assign brExt    = ADDR_W'(brDisp);
  assign callExt  = ADDR_W'(callDisp);
  assign wordOff  = strobe.callDisp ? callExt : brExt;
  assign byteOff  = wordOff << WORD_SHIFT;

  // Both adders wrap modulo 2^ADDR_W.
  assign targetAddr = pcQ + byteOff;
  assign seqAddr    = npcQ + STEP;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pcQ  <= RESET_PC;
      npcQ <= RESET_PC + STEP;
    end else if (strobe.advance) begin
      pcQ  <= npcQ;
      npcQ <= strobe.loadTarget ? targetAddr : seqAddr;
    end
  end

endmodule

// File: rtl/delay_slot_pc_seq.sv
module delay_slot_pc_seq
  import dsseq_pkg::*;
#(
  parameter int unsigned ADDR_W      = 32,
  parameter int unsigned BR_DISP_W   = 22,
  parameter int unsigned CALL_DISP_W = 30
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   retire,
  input  logic                   isBranch,
  input  logic                   isUncond,
  input  logic                   isCall,
  input  logic                   brTaken,
  input  logic                   annul,
  input  logic [CALL_DISP_W-1:0] dispIn,
  output logic [ADDR_W-1:0]      fetchPc,
  output logic [ADDR_W-1:0]      nextPc,
  output logic [ADDR_W-1:0]      target,
  output logic                   squash,
  output logic                   wbEn
);

  seqStrobe_t strobe;

  dsseq_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .retire   (retire),
    .isBranch (isBranch),
    .isUncond (isUncond),
    .isCall   (isCall),
    .brTaken  (brTaken),
    .annul    (annul),
    .strobe   (strobe),
    .squash   (squash),
    .wbEn     (wbEn)
  );

  dsseq_datapath #(
    .ADDR_W      (ADDR_W),
    .BR_DISP_W   (BR_DISP_W),
    .CALL_DISP_W (CALL_DISP_W),
    .RESET_PC    ('0)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .dispIn     (dispIn),
    .pcQ        (fetchPc),
    .npcQ       (nextPc),
    .targetAddr (target)
  );

endmodule

// File: rtl/dsseq_checker.sv
module dsseq_checker #(
  parameter int unsigned ADDR_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              retire,
  input logic              isBranch,
  input logic              isUncond,
  input logic              isCall,
  input logic              brTaken,
  input logic              annul,
  input logic [ADDR_W-1:0] fetchPc,
  input logic [ADDR_W-1:0] nextPc,
  input logic [ADDR_W-1:0] target,
  input logic              squash
);

  // R2
  hold_state_chk: assert property (@(posedge clk) disable iff (!rstN)
    !retire |=> ($stable(fetchPc) && $stable(nextPc) && $stable(squash)));

  // R3
  pc_follows_npc_chk: assert property (@(posedge clk) disable iff (!rstN)
    retire |=> fetchPc == $past(nextPc));

  // R4
  taken_loads_target_chk: assert property (@(posedge clk) disable iff (!rstN)
    (retire && !squash && isBranch && !isCall && brTaken) |=> nextPc == $past(target));

  // R6
  cond_taken_keeps_slot_chk: assert property (@(posedge clk) disable iff (!rstN)
    (retire && !squash && isBranch && !isCall && !isUncond && brTaken) |=> !squash);

  // R7
  uncond_annul_chk: assert property (@(posedge clk) disable iff (!rstN)
    (retire && !squash && isBranch && !isCall && isUncond && annul) |=> squash);

  // R8
  squashed_seq_chk: assert property (@(posedge clk) disable iff (!rstN)
    (retire && squash) |=> (!squash && nextPc == $past(nextPc) + ADDR_W'(4)));

  // R9
  word_aligned_chk: assert property (@(posedge clk) disable iff (!rstN)
    (fetchPc[1:0] == 2'b00) && (nextPc[1:0] == 2'b00) && (target[1:0] == 2'b00));

endmodule

bind delay_slot_pc_seq dsseq_checker #(.ADDR_W(ADDR_W)) u_dsseq_chk (
  .clk      (clk),
  .rstN     (rstN),
  .retire   (retire),
  .isBranch (isBranch),
  .isUncond (isUncond),
  .isCall   (isCall),
  .brTaken  (brTaken),
  .annul    (annul),
  .fetchPc  (fetchPc),
  .nextPc   (nextPc),
  .target   (target),
  .squash   (squash)
);

// File: tb/tb_delay_slot_pc_seq.sv
module tb_delay_slot_pc_seq;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        retire = 1'b0;
  logic        isBranch = 1'b0;
  logic        isUncond = 1'b0;
  logic        isCall = 1'b0;
  logic        brTaken = 1'b0;
  logic        annul = 1'b0;
  logic [29:0] dispIn = '0;
  logic [31:0] fetchPc, nextPc, target;
  logic        squash, wbEn;

  int nChecks = 0;
  int nFails  = 0;

  typedef struct {
    logic [31:0] pc;
    logic [31:0] npc;
    logic        sq;
    string       tag;
  } expItem_t;

  expItem_t expQ[$];

  // Reference state built from the requirements.
  logic [31:0] mPc, mNpc;
  logic        mAnn;

  always #(CLK_PERIOD/2) clk = ~clk;

  delay_slot_pc_seq dut (
    .clk(clk), .rstN(rstN), .retire(retire), .isBranch(isBranch),
    .isUncond(isUncond), .isCall(isCall), .brTaken(brTaken), .annul(annul),
    .dispIn(dispIn), .fetchPc(fetchPc), .nextPc(nextPc), .target(target),
    .squash(squash), .wbEn(wbEn)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Driver: applies one cycle of inputs and queues the state expected after the edge.
  task automatic step(input bit rt, input bit br, input bit un, input bit cl,
                      input bit tk, input bit an, input logic [29:0] d, input string tag);
    logic [31:0] expTgt;
    logic        live;
    expItem_t    it;
    @(negedge clk);
    retire = rt; isBranch = br; isUncond = un; isCall = cl;
    brTaken = tk; annul = an; dispIn = d;
    #1;
    expTgt = cl ? (mPc + ({{2{d[29]}}, d} << 2))
                : (mPc + ({{10{d[21]}}, d[21:0]} << 2));
    live = rt && !mAnn;
    // R11
    check(wbEn == live, {tag, " R11 wbEn"}, 32'(wbEn), 32'(live));
    check(target == expTgt, {tag, " target"}, target, expTgt);
    if (rt) begin
      mPc = mNpc;
      if (live && (cl || (br && tk))) mNpc = expTgt;
      else                            mNpc = mNpc + 32'd4;
      mAnn = live && br && !cl && an && (un || !tk);
    end
    it.pc = mPc; it.npc = mNpc; it.sq = mAnn; it.tag = tag;
    expQ.push_back(it);
  endtask

  // Monitor: compares the registered state shortly after each edge.
  always @(posedge clk) begin
    #2;
    if (expQ.size() > 0) begin
      expItem_t e;
      e = expQ.pop_front();
      check(fetchPc == e.pc,  {e.tag, " fetchPc"}, fetchPc, e.pc);
      check(nextPc  == e.npc, {e.tag, " nextPc"},  nextPc,  e.npc);
      check(squash  == e.sq,  {e.tag, " squash"},  32'(squash), 32'(e.sq));
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    nFails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    mPc = 32'h0; mNpc = 32'h4; mAnn = 1'b0;
    repeat (3) @(negedge clk);
    // R1: state during reset
    check(fetchPc == 32'h0, "R1 pc in reset", fetchPc, 32'h0);
    check(nextPc == 32'h4, "R1 npc in reset", nextPc, 32'h4);
    check(squash == 1'b0, "R1 squash in reset", 32'(squash), 32'h0);
    rstN = 1'b1;
    @(negedge clk);
    check(fetchPc == 32'h0 && nextPc == 32'h4, "R1 after release", fetchPc, 32'h0);

    // R2: hold with busy inputs
    step(0, 1, 0, 0, 1, 1, 30'h123, "R2 hold branch");
    step(0, 0, 0, 1, 0, 0, 30'h3FF, "R2 hold call");
    // R3: straight line
    step(1, 0, 0, 0, 0, 0, 30'h0, "R3 seq a");
    step(1, 0, 0, 0, 0, 0, 30'h0, "R3 seq b");
    // R4/R6: conditional taken with annul: slot executes
    step(1, 1, 0, 0, 1, 1, 30'h10, "R4 R6 cond taken annul");
    step(1, 0, 0, 0, 0, 0, 30'h0, "R4 delay slot");
    step(1, 0, 0, 0, 0, 0, 30'h0, "R4 at target");
    // R6: conditional not taken with annul: slot squashed
    step(1, 1, 0, 0, 0, 1, 30'h8, "R6 cond untaken annul");
    // R8: squashed slot carries a taken branch, ignored
    step(1, 1, 0, 0, 1, 0, 30'h40, "R8 squashed branch ignored");
    step(1, 0, 0, 0, 0, 0, 30'h0, "R8 after squash");
    // R6: no annul, not taken: no squash
    step(1, 1, 0, 0, 0, 0, 30'h8, "R6 cond untaken no annul");
    // R7: unconditional taken with annul
    step(1, 1, 1, 0, 1, 1, 30'h3FFFFD, "R7 always annul neg disp");
    step(1, 0, 0, 0, 0, 0, 30'h0, "R7 squashed slot");
    step(1, 0, 0, 0, 0, 0, 30'h0, "R7 at target");
    // R7: never with annul
    step(1, 1, 1, 0, 0, 1, 30'h20, "R7 never annul");
    step(1, 0, 0, 0, 0, 0, 30'h0, "R7 never slot");
    // R10: taken branch in delay slot of taken branch
    step(1, 1, 0, 0, 1, 0, 30'h100, "R10 first branch");
    step(1, 1, 0, 0, 1, 0, 30'h200, "R10 branch in slot");
    step(1, 0, 0, 0, 0, 0, 30'h0, "R10 first target");
    step(1, 0, 0, 0, 0, 0, 30'h0, "R10 second target");
    // R5/R9: call with annul set, wraps below zero
    step(1, 1, 0, 1, 0, 1, 30'h3FF00000, "R5 R9 call wrap");
    step(1, 0, 0, 0, 0, 0, 30'h0, "R5 call slot");
    step(1, 0, 0, 0, 0, 0, 30'h0, "R9 wrapped pc");
    // R9: forward branch wraps above top
    step(1, 1, 0, 0, 1, 0, 30'h1FFFFF, "R9 branch wrap");
    step(1, 0, 0, 0, 0, 0, 30'h0, "R9 slot");
    step(0, 0, 0, 0, 0, 0, 30'h0, "R2 final hold");
    repeat (3) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule